// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break and In-Progress Flags

This block receives asynchronous serial characters on a single line input, using a supplied 16x oversample tick. The line is resynchronised, and a low level during the idle search starts a candidate start bit. That start bit is confirmed by a three-sample vote in its first half. Each data bit and the stop bit are then taken by a three-sample majority around the bit centre. A mode input selects 8 or 9 data bits.

A small status word sits beside the data path. It holds five flags: received-data-full, framing error, break detected, reception in progress, and an arm bit for the two-step clear. The break flag is cleared by reading the status word while a flag is set and then reading the data. After a break, the flag cannot set again until the line has been seen high. One data port returns the received character on a read and captures a transmit byte on a write. Reset leaves both data registers untouched.

Top module: `uart_rx_brk`

## Requirements
- R1: A character is a 0 start bit, then 8 data bits (`nine_i`=0) or 9 data bits (`nine_i`=1) sent LSB first, then a stop bit, with each bit lasting 16 ticks. Once the character completes, `rdata_o` holds data bits 7..0. `rx_bit8_o` holds the ninth bit, or 0 in 8-bit mode.
- R2: Every completed character sets the full flag (`stat_o[3]`). A stop bit sampled as 0 also sets the framing-error flag (`stat_o[2]`).
- R3: A character whose data bits and stop bit are all 0 sets the break flag (`stat_o[1]`) together with the full and framing-error flags. In 9-bit mode `rx_bit8_o` then reads 0.
- R4: A status read (`rd_stat_i`) while any of the break, framing-error or full flags is set sets the arm bit (`stat_o[4]`). A data read (`rd_data_i`) that follows clears the break, framing-error, full and arm bits.
- R5: A data read while the arm bit is clear leaves every flag as it was. A status write (`wr_stat_i`) clears the arm bit, so a later data read leaves the break flag set.
- R6: Once a break has set the flag, a further all-zero character received with no tick-sampled 1 in between sets the full and framing-error flags but not the break flag. A break received after the line has been sampled at 1 sets the break flag again.
- R7: The in-progress flag (`stat_o[0]`) sets on the first tick that samples 0 while the receiver is searching for a start bit.
- R8: If at least two of the start-bit samples at ticks 3, 5 and 7 are 1, the start is false. The in-progress flag clears and no character is delivered.
- R9: The in-progress flag clears once the line has been sampled at 1 on 160 consecutive ticks (8-bit mode) or 176 (9-bit mode), and not before.
- R10: A data write (`wr_data_i`) places `wdata_i` on `tx_data_o`. Reset clears all status bits and changes neither `tx_data_o` nor `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd_i | input | 1 | Serial line, idle high |
| nine_i | input | 1 | 1 selects 9 data bits |
| rd_stat_i | input | 1 | Status read strobe |
| wr_stat_i | input | 1 | Status write strobe |
| rd_data_i | input | 1 | Data read strobe |
| wr_data_i | input | 1 | Data write strobe |
| wdata_i | input | 8 | Transmit byte for data writes |
| stat_o | output | 8 | {3'b0, arm, full, framing error, break, in progress} |
| rdata_o | output | 8 | Received data bits 7..0 |
| rx_bit8_o | output | 1 | Received ninth data bit |
| tx_data_o | output | 8 | Last written transmit byte |

## Verification
The bench walks a character table that mixes both widths, valid stops, a framing error and breaks in both modes. One entry is a 9-bit break that directly follows a character with the ninth bit at 1, so a design that kept the stale ninth bit is caught. The two-step clear is attacked by a data read without a prior status read and by a status write between the two reads. A design that cleared on either would drop the break flag early. A line held low through two back-to-back break characters shows whether the break flag re-arms without a high level. A short low glitch shows whether the in-progress flag sets and then clears on a false start. The idle check samples the in-progress flag 16 ticks short of the idle length and again after it, exposing an idle counter with the wrong length. A reset between a data write and the next read shows whether the data registers wrongly carry a reset.

// File: rtl/uart_rx_brk_pkg.sv
package uart_rx_brk_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  localparam int unsigned ST_RIP  = 0;
  localparam int unsigned ST_BRK  = 1;
  localparam int unsigned ST_FE   = 2;
  localparam int unsigned ST_FULL = 3;
  localparam int unsigned ST_ARM  = 4;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/brk_rx_core.sv
module brk_rx_core
  import uart_rx_brk_pkg::*;
#(
  parameter int unsigned OSR = 16,
  parameter int unsigned DW  = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic          nine_i,
  output logic          start_o,
  output logic          false_o,
  output logic          done_o,
  output logic          stop_o,
  output logic [DW-1:0] data_o
);
  localparam int unsigned RTW = $clog2(OSR);
  localparam int unsigned BW  = $clog2(DW + 1);
  localparam int unsigned MID = OSR / 2;

  rx_state_e      st_q;
  logic [RTW-1:0] rt_q;
  logic [BW-1:0]  idx_q;
  logic [1:0]     vote_q;
  logic [DW-1:0]  sh_q;

  logic           last_rt, vote_now;
  logic [BW-1:0]  nbits;

  assign last_rt  = (rt_q == RTW'(OSR - 1));
  assign vote_now = maj3(vote_q[0], vote_q[1], rxd_i);
  assign nbits    = nine_i ? BW'(DW) : BW'(DW - 1);

  assign start_o = tick_i && (st_q == RX_IDLE) && !rxd_i;
  // start-bit vote is decided at RT7 (index MID-2)
  assign false_o = tick_i && (st_q == RX_START) && (rt_q == RTW'(MID - 2)) && vote_now;
  assign done_o  = tick_i && (st_q == RX_STOP) && (rt_q == RTW'(MID + 1));
  assign stop_o  = vote_now;
  assign data_o  = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      rt_q   <= '0;
      idx_q  <= '0;
      vote_q <= '0;
      sh_q   <= '0;
    end else if (tick_i) begin
      unique case (st_q)
        RX_IDLE: begin
          if (!rxd_i) begin
            st_q <= RX_START;
            rt_q <= RTW'(1);
            sh_q <= '0;
          end
        end
        RX_START: begin
          rt_q <= last_rt ? '0 : rt_q + RTW'(1);
          if (rt_q == RTW'(MID - 6)) vote_q[0] <= rxd_i;
          if (rt_q == RTW'(MID - 4)) vote_q[1] <= rxd_i;
          if (false_o) begin
            st_q <= RX_IDLE;
            rt_q <= '0;
          end else if (last_rt) begin
            st_q  <= RX_DATA;
            idx_q <= '0;
          end
        end
        RX_DATA: begin
          rt_q <= last_rt ? '0 : rt_q + RTW'(1);
          if (rt_q == RTW'(MID - 1)) vote_q[0] <= rxd_i;
          if (rt_q == RTW'(MID))     vote_q[1] <= rxd_i;
          if (rt_q == RTW'(MID + 1)) begin
            for (int i = 0; i < int'(DW); i++)
              if (idx_q == BW'(i)) sh_q[i] <= vote_now;
          end
          if (last_rt) begin
            if (idx_q == nbits - BW'(1)) st_q <= RX_STOP;
            else                         idx_q <= idx_q + BW'(1);
          end
        end
        RX_STOP: begin
          rt_q <= rt_q + RTW'(1);
          if (rt_q == RTW'(MID - 1)) vote_q[0] <= rxd_i;
          if (rt_q == RTW'(MID))     vote_q[1] <= rxd_i;
          if (done_o) begin
            st_q <= RX_IDLE;
            rt_q <= '0;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/brk_status.sv
module brk_status
  import uart_rx_brk_pkg::*;
#(
  parameter int unsigned OSR = 16,
  parameter int unsigned DW  = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic          nine_i,
  input  logic          start_i,
  input  logic          false_i,
  input  logic          done_i,
  input  logic          stop_i,
  input  logic [DW-1:0] data_i,
  input  logic          rd_stat_i,
  input  logic          wr_stat_i,
  input  logic          rd_data_i,
  input  logic          wr_data_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    stat_o,
  output logic [7:0]    rdata_o,
  output logic          rx_bit8_o,
  output logic [7:0]    tx_data_o
);
  localparam int unsigned IDLE_LONG  = OSR * (DW + 2);
  localparam int unsigned IDLE_SHORT = OSR * (DW + 1);
  localparam int unsigned ICW        = $clog2(IDLE_LONG + 1);

  logic [ICW-1:0] ones_q, idle_lim;
  logic idle_hit, brk_char, rd_clear;
  logic rip_q, brk_q, fe_q, full_q, arm_q, rearm_q;
  logic [7:0] rx_q, tx_q;
  logic       rx_b8_q;

  assign idle_lim = nine_i ? ICW'(IDLE_LONG) : ICW'(IDLE_SHORT);
  assign idle_hit = tick_i && rxd_i && (ones_q == idle_lim - ICW'(1));
  assign brk_char = done_i && !stop_i && (data_i == '0);
  assign rd_clear = rd_data_i && arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ones_q <= '0;
    else if (tick_i) begin
      if (!rxd_i)         ones_q <= '0;
      else if (ones_q != '1) ones_q <= ones_q + ICW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rip_q   <= 1'b0;
      brk_q   <= 1'b0;
      fe_q    <= 1'b0;
      full_q  <= 1'b0;
      arm_q   <= 1'b0;
      rearm_q <= 1'b1;
    end else begin
      if (start_i)                 rip_q <= 1'b1;
      else if (false_i || idle_hit) rip_q <= 1'b0;

      // a new character wins over a clear in the same cycle
      full_q <= done_i | (full_q & ~rd_clear);
      fe_q   <= (done_i & ~stop_i) | (fe_q & ~rd_clear);
      brk_q  <= (brk_char & rearm_q) | (brk_q & ~rd_clear);

      if (brk_char)                rearm_q <= 1'b0;
      else if (tick_i && rxd_i)    rearm_q <= 1'b1;

      if (rd_clear || wr_stat_i)   arm_q <= 1'b0;
      else if (rd_stat_i && (brk_q || fe_q || full_q)) arm_q <= 1'b1;
    end
  end

  // data registers carry no reset
  always_ff @(posedge clk_i) begin
    if (done_i) begin
      rx_q    <= data_i[7:0];
      rx_b8_q <= nine_i & data_i[DW-1];
    end
  end

  always_ff @(posedge clk_i)
    if (wr_data_i) tx_q <= wdata_i;

  always_comb begin
    stat_o          = '0;
    stat_o[ST_RIP]  = rip_q;
    stat_o[ST_BRK]  = brk_q;
    stat_o[ST_FE]   = fe_q;
    stat_o[ST_FULL] = full_q;
    stat_o[ST_ARM]  = arm_q;
  end

  assign rdata_o   = rx_q;
  assign rx_bit8_o = rx_b8_q;
  assign tx_data_o = tx_q;
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk #(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic       nine_i,
  input  logic       rd_stat_i,
  input  logic       wr_stat_i,
  input  logic       rd_data_i,
  input  logic       wr_data_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] stat_o,
  output logic [7:0] rdata_o,
  output logic       rx_bit8_o,
  output logic [7:0] tx_data_o
);
  localparam int unsigned DW = 9;

  logic          rxd_s, start_w, false_w, done_w, stop_w;
  logic [DW-1:0] data_w;

  brk_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  brk_rx_core #(.OSR(OSR), .DW(DW)) i_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .rxd_i  (rxd_s),
    .nine_i (nine_i),
    .start_o(start_w),
    .false_o(false_w),
    .done_o (done_w),
    .stop_o (stop_w),
    .data_o (data_w)
  );

  brk_status #(.OSR(OSR), .DW(DW)) i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .rxd_i    (rxd_s),
    .nine_i   (nine_i),
    .start_i  (start_w),
    .false_i  (false_w),
    .done_i   (done_w),
    .stop_i   (stop_w),
    .data_i   (data_w),
    .rd_stat_i(rd_stat_i),
    .wr_stat_i(wr_stat_i),
    .rd_data_i(rd_data_i),
    .wr_data_i(wr_data_i),
    .wdata_i  (wdata_i),
    .stat_o   (stat_o),
    .rdata_o  (rdata_o),
    .rx_bit8_o(rx_bit8_o),
    .tx_data_o(tx_data_o)
  );
endmodule

// File: rtl/uart_rx_brk_chk.sv
module uart_rx_brk_chk
  import uart_rx_brk_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       rd_stat_i,
  input logic       wr_stat_i,
  input logic       rd_data_i,
  input logic [4:0] stat_i
);
  p_brk_with_fe_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i[ST_BRK]) |-> (stat_i[ST_FE] && stat_i[ST_FULL]));

  p_brk_clear_seq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_i[ST_BRK]) |-> ($past(rd_data_i) && $past(stat_i[ST_ARM])));

  p_arm_needs_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i[ST_ARM] |-> (stat_i[ST_BRK] || stat_i[ST_FE] || stat_i[ST_FULL]));

  p_wr_stat_disarms_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_i && !rd_stat_i) |=> !stat_i[ST_ARM]);

  p_full_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i[ST_FULL]) |-> $past(tick_i));

  p_rip_on_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_i[ST_RIP]) |-> $past(tick_i));
endmodule

bind uart_rx_brk uart_rx_brk_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .rd_stat_i(rd_stat_i),
  .wr_stat_i(wr_stat_i),
  .rd_data_i(rd_data_i),
  .stat_i   (stat_o[4:0])
);

// File: tb/test_uart_rx_brk.sv
module test_uart_rx_brk;
  localparam int CLK_P = 10;
  localparam int NVEC  = 8;
  // {nine, bits[8:0], stop, exp_fe, exp_brk}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 9'h0A5, 1'b1, 1'b0, 1'b0},
    {1'b0, 9'h03C, 1'b1, 1'b0, 1'b0},
    {1'b1, 9'h1FF, 1'b1, 1'b0, 1'b0},
    {1'b1, 9'h000, 1'b0, 1'b1, 1'b1},
    {1'b0, 9'h081, 1'b0, 1'b1, 1'b0},
    {1'b0, 9'h000, 1'b0, 1'b1, 1'b1},
    {1'b1, 9'h155, 1'b1, 1'b0, 1'b0},
    {1'b0, 9'h000, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1, nine = 1'b0;
  logic rd_stat = 1'b0, wr_stat = 1'b0, rd_data = 1'b0, wr_data = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] stat, rdata, txd;
  logic       bit8;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  uart_rx_brk i_uart_rx_brk (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd), .nine_i(nine),
    .rd_stat_i(rd_stat), .wr_stat_i(wr_stat), .rd_data_i(rd_data), .wr_data_i(wr_data),
    .wdata_i(wdata), .stat_o(stat), .rdata_o(rdata), .rx_bit8_o(bit8), .tx_data_o(txd)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    tick_n(16);
  endtask

  // stop bit held only up to its vote, then line returns high
  task automatic send_frame(input logic nm, input logic [8:0] bits, input logic stp);
    nine = nm;
    send_bit(1'b0);
    for (int i = 0; i < (nm ? 9 : 8); i++) send_bit(bits[i]);
    rxd = stp;
    tick_n(10);
    rxd = 1'b1;
    tick_n(6);
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: rd_stat = 1'b1;
      1: rd_data = 1'b1;
      2: wr_stat = 1'b1;
      default: wr_data = 1'b1;
    endcase
    @(negedge clk);
    rd_stat = 1'b0; rd_data = 1'b0; wr_stat = 1'b0; wr_data = 1'b0;
  endtask

  task automatic clear_flags();
    strobe(0);
    strobe(1);
  endtask

  task automatic wait_full();
    int n = 0;
    while (!stat[3] && n < 400) begin
      tick_n(1);
      n++;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset status", int'(stat), 0);

    // character table
    for (int v = 0; v < NVEC; v++) begin
      send_frame(VEC[v][12], VEC[v][11:3], VEC[v][2]);
      chk("R2 full", int'(stat[3]), 1);
      chk("R2 fe", int'(stat[2]), int'(VEC[v][1]));
      chk("R3 brk", int'(stat[1]), int'(VEC[v][0]));
      chk("R1 data", int'(rdata), int'(VEC[v][10:3]));
      chk("R1 bit8", int'(bit8), int'(VEC[v][12] & VEC[v][11]));
      rxd = 1'b1;
      tick_n(16 * 11);
      clear_flags();
      chk("R4 flags cleared", int'(stat[4:1]), 0);
    end
    nine = 1'b0;

    // false start
    rxd = 1'b0;
    tick_n(2);
    chk("R7 rip set", int'(stat[0]), 1);
    rxd = 1'b1;
    tick_n(14);
    chk("R8 rip cleared", int'(stat[0]), 0);
    chk("R8 no char", int'(stat[3]), 0);

    // idle length, 8-bit mode
    send_frame(1'b0, 9'h000, 1'b1);
    chk("R9 rip held", int'(stat[0]), 1);
    tick_n(16 * 8);
    chk("R9 rip before idle", int'(stat[0]), 1);
    tick_n(32);
    chk("R9 rip after idle", int'(stat[0]), 0);
    clear_flags();

    // two-step clear
    send_frame(1'b0, 9'h000, 1'b0);
    chk("R3 brk set", int'(stat[1]), 1);
    strobe(1);
    chk("R5 data read unarmed brk", int'(stat[1]), 1);
    chk("R5 data read unarmed full", int'(stat[3]), 1);
    strobe(0);
    chk("R4 arm set", int'(stat[4]), 1);
    strobe(2);
    chk("R5 wr_stat disarms", int'(stat[4]), 0);
    strobe(1);
    chk("R5 brk kept", int'(stat[1]), 1);
    strobe(0);
    strobe(1);
    chk("R4 brk cleared", int'(stat[1]), 0);
    chk("R4 arm cleared", int'(stat[4]), 0);

    // re-arm: line held low across two breaks
    rxd = 1'b0;
    wait_full();
    chk("R6 first brk", int'(stat[1]), 1);
    clear_flags();
    chk("R6 brk cleared", int'(stat[1]), 0);
    wait_full();
    chk("R6 no brk without 1s", int'(stat[1]), 0);
    chk("R6 fe still set", int'(stat[2]), 1);
    rxd = 1'b1;
    tick_n(16);
    clear_flags();
    send_frame(1'b0, 9'h000, 1'b0);
    chk("R6 brk rearmed", int'(stat[1]), 1);

    // data registers across reset
    wdata = 8'hA5;
    strobe(3);
    chk("R10 tx write", int'(txd), 'hA5);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 tx kept", int'(txd), 'hA5);
    chk("R10 rx kept", int'(rdata), 0);
    chk("R10 flags reset", int'(stat), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule